// File: doc/BRIEF.md
# Programmable periodic interval timer

This block raises a periodic interrupt at a rate set by software. A prescaler divides the system clock down to a one-millisecond strobe. A period counter counts those strobes. With a reload value R, the counter ends a period every R+1 milliseconds, raises the interrupt and begins the next period at once.

The interrupt is a level. It stays high until software acknowledges it or reprograms the timer. Software reaches the block through a simple 32-bit register port that takes byte, halfword and word accesses:

- Writing the reload register stores the new value, drops the interrupt and starts the period again from zero.
- Any read of the count register acknowledges the interrupt. The count register always reads as zero.

Top module: `ivt_timer`

## Requirements
- R1: After a restart, the interrupt output rises on the clock edge exactly (R+1)*(CLK_HZ/TICK_HZ) cycles later, where R is the stored reload value. It stays low on every earlier edge.
- R2: At the end of each period the next period starts at once, without software action. The interrupt therefore becomes set again (R+1)*(CLK_HZ/TICK_HZ) cycles after the previous expiry.
- R3: A write of any size to the reload word (byte offset 0x228) does three things: it stores the merged value, it leaves the interrupt low after that edge, and it restarts the prescaler and the period counter from zero.
- R4: A read of any size to the count word (byte offset 0x230) leaves the interrupt low after that edge, unless a period expires on the same edge.
- R5: Reads of the count word return zero on every byte lane.
- R6: Reset clears the reload value to 0 and drives the interrupt low.
- R7: req_size encodes the access width: 0 is a byte, 1 is a halfword, 2 or 3 is a word.
  - A byte write puts req_wdata[7:0] into lane req_addr[1:0]. A halfword write puts req_wdata[15:0] into halfword req_addr[1]. The other bits of the stored value are kept.
  - Reads return the selected lane shifted down to bit 0, with the unused upper bits zero.
  - The reload word reads back as the stored value.
- R8: If a period expires on the same edge as an acknowledge read, the interrupt is high after that edge.
- R9: Once high, the interrupt stays high until an acknowledge read or a reload write.
- R10: Writes to the count word or to unmapped offsets leave the reload value and the timing unchanged. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access strobe; one access per cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Access width: 0 byte, 1 halfword, 2/3 word |
| req_wdata | input | 32 | Write data, right-aligned for sub-word writes |
| rsp_rdata | output | 32 | Read data for the current access (combinational) |
| irq_o | output | 1 | Periodic interrupt level |

## Verification
The hardest case to reach from the ports is an acknowledge read that lands on the same clock edge as a period expiry (R8). The bench keeps a free-running edge counter and records the edge on which a reload write took effect. From that edge it counts forward whole periods, waits until the cycle before the third expiry and issues the count read so that it is sampled on exactly that edge. It then checks that the interrupt is still high. A restart in mid-period is also forced: a second reload write arrives part-way through a period, and the bench checks that no interrupt appears before a full period measured from the second write.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

   localparam int BUS_W = 32;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   // Replace the addressed lane of old_w by the right-aligned write data.
   function automatic logic [BUS_W-1:0] lane_merge(
      input logic [BUS_W-1:0] old_w,
      input logic [BUS_W-1:0] wdata,
      input logic [1:0]       size,
      input logic [1:0]       lane
   );
      logic [BUS_W-1:0] r;
      r = old_w;
      case (size)
         SZ_BYTE: r[{lane, 3'b000} +: 8]        = wdata[7:0];
         SZ_HALF: r[{lane[1], 4'b0000} +: 16]   = wdata[15:0];
         default: r                             = wdata;
      endcase
      return r;
   endfunction

   // Bring the addressed lane down to bit 0, zero-filling above it.
   function automatic logic [BUS_W-1:0] lane_extract(
      input logic [BUS_W-1:0] word,
      input logic [1:0]       size,
      input logic [1:0]       lane
   );
      logic [BUS_W-1:0] r;
      r = '0;
      case (size)
         SZ_BYTE: r[7:0]  = word[{lane, 3'b000} +: 8];
         SZ_HALF: r[15:0] = word[{lane[1], 4'b0000} +: 16];
         default: r       = word;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
   parameter int DIV = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   output logic tick_o
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   logic [PW-1:0] pcnt_q;

   assign tick_o = (pcnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || restart_i || tick_o) pcnt_q <= '0;
      else                               pcnt_q <= pcnt_q + PW'(1);
   end
endmodule

// File: rtl/ivt_period.sv
module ivt_period #(
   parameter int RELOAD_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart_i,
   input  logic                tick_i,
   input  logic [RELOAD_W-1:0] reload_i,
   output logic                expire_o
);
   logic [RELOAD_W-1:0] cnt_q;
   logic                at_end;

   assign at_end   = (cnt_q == reload_i);
   assign expire_o = tick_i & at_end;

   always_ff @(posedge clk) begin
      if (!rst_n || restart_i) cnt_q <= '0;
      else if (tick_i) begin
         if (at_end) cnt_q <= '0;
         else        cnt_q <= cnt_q + RELOAD_W'(1);
      end
   end
endmodule

// File: rtl/ivt_regif.sv
module ivt_regif
   import ivt_pkg::*;
#(
   parameter int ADDR_W     = 14,
   parameter int RELOAD_W   = 32,
   parameter int RELOAD_OFS = 'h228,
   parameter int COUNT_OFS  = 'h230
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [1:0]          req_size,
   input  logic [BUS_W-1:0]    req_wdata,
   output logic [BUS_W-1:0]    rsp_rdata,
   output logic [RELOAD_W-1:0] reload_o,
   output logic                reload_wr_o,
   output logic                ack_o
);
   localparam logic [ADDR_W-1:0] RL_A = ADDR_W'(RELOAD_OFS);
   localparam logic [ADDR_W-1:0] CT_A = ADDR_W'(COUNT_OFS);

   logic              hit_rl, hit_ct;
   logic [BUS_W-1:0]  cur_word, merged;
   logic [RELOAD_W-1:0] reload_q;

   assign hit_rl = (req_addr[ADDR_W-1:2] == RL_A[ADDR_W-1:2]);
   assign hit_ct = (req_addr[ADDR_W-1:2] == CT_A[ADDR_W-1:2]);

   assign reload_wr_o = req_valid & req_write & hit_rl;
   assign ack_o       = req_valid & ~req_write & hit_ct;

   always_comb begin
      cur_word                 = '0;
      cur_word[RELOAD_W-1:0]   = reload_q;
   end

   assign merged = lane_merge(cur_word, req_wdata, req_size, req_addr[1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n)           reload_q <= '0;
      else if (reload_wr_o) reload_q <= merged[RELOAD_W-1:0];
   end

   // Count word and unmapped offsets read as zero.
   assign rsp_rdata = (req_valid && !req_write && hit_rl)
                      ? lane_extract(cur_word, req_size, req_addr[1:0])
                      : '0;

   assign reload_o = reload_q;
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer #(
   parameter int CLK_HZ     = 100_000_000,
   parameter int TICK_HZ    = 1000,
   parameter int ADDR_W     = 14,
   parameter int RELOAD_W   = 32,
   parameter int RELOAD_OFS = 'h228,
   parameter int COUNT_OFS  = 'h230
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [31:0]       req_wdata,
   output logic [31:0]       rsp_rdata,
   output logic              irq_o
);
   localparam int DIV = CLK_HZ / TICK_HZ;

   generate
      if (TICK_HZ < 1 || CLK_HZ < TICK_HZ || (CLK_HZ % TICK_HZ) != 0) begin : g_bad_div
         $error("ivt_timer: CLK_HZ must be a whole multiple of TICK_HZ");
      end
      if (RELOAD_W < 1 || RELOAD_W > 32) begin : g_bad_rw
         $error("ivt_timer: RELOAD_W must lie in 1..32");
      end
      if (ADDR_W < 3 || (RELOAD_OFS % 4) != 0 || (COUNT_OFS % 4) != 0
          || RELOAD_OFS == COUNT_OFS) begin : g_bad_map
         $error("ivt_timer: register offsets must be distinct aligned words");
      end
   endgenerate

   logic [RELOAD_W-1:0] reload_w;
   logic                restart_w, ack_w, tick_w, expire_w;
   logic                irq_q;

   ivt_regif #(
      .ADDR_W(ADDR_W), .RELOAD_W(RELOAD_W),
      .RELOAD_OFS(RELOAD_OFS), .COUNT_OFS(COUNT_OFS)
   ) u_regif (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_size(req_size), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
      .reload_o(reload_w), .reload_wr_o(restart_w), .ack_o(ack_w)
   );

   ivt_prescaler #(.DIV(DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart_i(restart_w), .tick_o(tick_w)
   );

   ivt_period #(.RELOAD_W(RELOAD_W)) u_per (
      .clk(clk), .rst_n(rst_n), .restart_i(restart_w),
      .tick_i(tick_w), .reload_i(reload_w), .expire_o(expire_w)
   );

   // Priority: reprogramming, then expiry, then acknowledge.
   always_ff @(posedge clk) begin
      if (!rst_n || restart_w) irq_q <= 1'b0;
      else if (expire_w)       irq_q <= 1'b1;
      else if (ack_w)          irq_q <= 1'b0;
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
   parameter int ADDR_W     = 14,
   parameter int RELOAD_OFS = 'h228,
   parameter int COUNT_OFS  = 'h230
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [31:0]       rsp_rdata,
   input logic              expire,
   input logic              irq
);
   localparam logic [ADDR_W-1:0] RL_A = ADDR_W'(RELOAD_OFS);
   localparam logic [ADDR_W-1:0] CT_A = ADDR_W'(COUNT_OFS);

   logic wr_rl, rd_ct;
   assign wr_rl = req_valid && req_write && (req_addr[ADDR_W-1:2] == RL_A[ADDR_W-1:2]);
   assign rd_ct = req_valid && !req_write && (req_addr[ADDR_W-1:2] == CT_A[ADDR_W-1:2]);

   AST_WRITE_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rl |=> !irq); // R3
   AST_ACK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ct && !expire) |=> !irq); // R4
   AST_COUNT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ct |-> (rsp_rdata == 32'd0)); // R5
   AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !wr_rl) |=> irq); // R8
   AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !wr_rl && !rd_ct) |=> irq); // R9
   AST_RISE_ONLY_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !expire) |=> !irq); // R2
endmodule

bind ivt_timer ivt_checker #(
   .ADDR_W(ADDR_W), .RELOAD_OFS(RELOAD_OFS), .COUNT_OFS(COUNT_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .rsp_rdata(rsp_rdata), .expire(expire_w), .irq(irq_o)
);

// File: tb/sim_ivt_timer.sv
module sim_ivt_timer;
   localparam int CLK_HZ = 8000;
   localparam int DIV    = 8;
   localparam logic [13:0] A_RL = 14'h228;
   localparam logic [13:0] A_CT = 14'h230;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [13:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata;
   logic        irq_o;

   int cyc = 0;
   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ivt_timer #(.CLK_HZ(CLK_HZ), .TICK_HZ(1000)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_rdata(rsp_rdata), .irq_o(irq_o)
   );

   // {addr[13:0], size[1:0], wdata[31:0], expected reload[31:0]}
   localparam logic [79:0] VEC [8] = '{
      {14'h228, 2'd2, 32'h12345678, 32'h12345678},
      {14'h229, 2'd0, 32'h000000AB, 32'h1234AB78},
      {14'h22A, 2'd1, 32'h0000BEEF, 32'hBEEFAB78},
      {14'h22B, 2'd0, 32'h00000001, 32'h01EFAB78},
      {14'h228, 2'd1, 32'h00000003, 32'h01EF0003},
      {14'h230, 2'd2, 32'hFFFFFFFF, 32'h01EF0003},
      {14'h200, 2'd2, 32'hFFFFFFFF, 32'h01EF0003},
      {14'h22A, 2'd0, 32'h00000055, 32'h01550003}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic bus_write(input logic [13:0] a, input logic [1:0] s,
                            input logic [31:0] d, output int edge_no);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
      @(posedge clk); #1;
      edge_no = cyc;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic bus_read(input logic [13:0] a, input logic [1:0] s,
                           output logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = s;
      #1 d = rsp_rdata;
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic wait_edge(input int n);
      while (cyc < n) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic logic [31:0] model_read(input logic [13:0] a, input logic [1:0] s,
                                               input logic [31:0] rl);
      if (a[13:2] != A_RL[13:2]) return 32'd0;
      case (s)
         2'd0:    return (rl >> (8 * a[1:0])) & 32'hFF;
         2'd1:    return (rl >> (16 * a[1])) & 32'hFFFF;
         default: return rl;
      endcase
   endfunction

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int te, te2, te3, te4;

      // Reset state (R6)
      do_reset();
      @(negedge clk);
      chk("R6 irq after reset", {31'b0, irq_o}, 32'd0);
      bus_read(A_RL, 2'd2, rd);
      chk("R6 reload after reset", rd, 32'd0);

      // Register vectors: merge, readback, ignored writes (R7, R10, R5)
      for (int i = 0; i < 8; i++) begin
         logic [13:0] va;
         logic [1:0]  vs;
         logic [31:0] vd, ve;
         {va, vs, vd, ve} = VEC[i];
         bus_write(va, vs, vd, te);
         bus_read(A_RL, 2'd2, rd);
         chk((i == 5 || i == 6) ? "R10 reload unchanged" : "R7 merged reload", rd, ve);
         bus_read(va, vs, rd);
         chk((va[13:2] == A_CT[13:2]) ? "R5 count read" :
             (va[13:2] == A_RL[13:2]) ? "R7 lane read" : "R10 unmapped read",
             rd, model_read(va, vs, ve));
      end

      // Period of (2+1) ms = 24 cycles (R1)
      bus_write(A_RL, 2'd2, 32'd2, te);
      wait_edge(te + 23);
      chk("R1 no irq before period end", {31'b0, irq_o}, 32'd0);
      wait_edge(te + 24);
      chk("R1 irq at period end", {31'b0, irq_o}, 32'd1);
      wait_edge(te + 30);
      chk("R9 irq level held", {31'b0, irq_o}, 32'd1);

      bus_read(A_CT, 2'd2, rd);
      chk("R5 count reads zero", rd, 32'd0);
      chk("R4 ack clears irq", {31'b0, irq_o}, 32'd0);

      wait_edge(te + 47);
      chk("R2 no early re-rise", {31'b0, irq_o}, 32'd0);
      wait_edge(te + 48);
      chk("R2 automatic next period", {31'b0, irq_o}, 32'd1);
      bus_read(A_CT, 2'd0, rd);
      chk("R4 byte ack clears irq", {31'b0, irq_o}, 32'd0);

      // Ack sampled on the expiry edge te+72 (R8)
      wait_edge(te + 71);
      bus_read(A_CT, 2'd2, rd);
      chk("R8 ack on expiry edge timing", cyc, te + 72);
      chk("R8 expiry wins over ack", {31'b0, irq_o}, 32'd1);

      // Reload write clears irq and restarts (R3), R = 0 -> 8 cycles (R1)
      bus_write(A_RL, 2'd2, 32'd0, te2);
      chk("R3 reload write clears irq", {31'b0, irq_o}, 32'd0);
      wait_edge(te2 + 7);
      chk("R1 R=0 no early irq", {31'b0, irq_o}, 32'd0);
      wait_edge(te2 + 8);
      chk("R1 R=0 irq after one ms", {31'b0, irq_o}, 32'd1);

      // Mid-period rewrite restarts timing from zero (R3)
      bus_write(A_RL, 2'd2, 32'd3, te3);
      wait_edge(te3 + 20);
      bus_write(A_RL, 2'd2, 32'd3, te4);
      wait_edge(te4 + 31);
      chk("R3 restart delays expiry", {31'b0, irq_o}, 32'd0);
      wait_edge(te4 + 32);
      chk("R3 full period after restart", {31'b0, irq_o}, 32'd1);

      // Count-word write does not acknowledge or restart (R10)
      bus_write(A_CT, 2'd2, 32'hFFFFFFFF, te);
      chk("R10 count write ignored", {31'b0, irq_o}, 32'd1);

      // Reset while running (R6)
      do_reset();
      @(negedge clk);
      chk("R6 irq low after reset", {31'b0, irq_o}, 32'd0);
      bus_read(A_RL, 2'd2, rd);
      chk("R6 reload zero after reset", rd, 32'd0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule